// File: doc/BRIEF.md
# Space-Vector PWM Modulator

This block turns a voltage command in the stationary two-axis frame into switching signals for a two-level, three-phase inverter bridge. Each clock it decodes which of the six 60-degree sectors the command lies in. It projects the command onto the two active switching states that bound that sector. The remainder of the carrier period goes to the zero states, split evenly between the all-low and all-high states. The result is three high-side on-times measured in carrier counts.

A symmetric up/down counter forms the triangle carrier. Its peak is derived from the system clock and the switching frequency. A high-side gate is on while the carrier is below that phase's on-time, and the low-side gate is its inverse. Commands are staged every cycle, but the on-times in use change only at the carrier valley, so a pulse is never cut short. A gain input scales the command relative to the DC-link voltage. A command beyond the hexagon boundary is shrunk along its own direction until it just fits.

Top module: `svpwm_mod`

## Requirements
- R1: While rst_n is low, gate_hi is 3'b000 and gate_lo is 3'b111.
- R2: period_stb is high for exactly one cycle every 2·PK clocks, where PK = CLK_HZ/(2·PWM_HZ). With the defaults, PK is 625 and the period is 1250 clocks.
- R3: In every cycle, gate_lo equals the bitwise inverse of gate_hi.
- R4: In the linear range, each phase's high-side on-time per carrier period is 2·PK·(1/2 + v − (vmax+vmin)/2), within ±6 clocks. Bits 0, 1 and 2 of the gate buses are phases a, b and c. The phase voltages are va = n·α, vb = n·(−α/2 + (√3/2)·β) and vc = n·(−α/2 − (√3/2)·β), as fractions of the DC link. Commands are signed Q1.15 and n = vdc_gain/2^14, so vdc_gain is unsigned Q2.14.
- R5: In the linear range, the zero-vector time is split evenly. The on-times of the longest and shortest phase add up to one carrier period within ±6 clocks.
- R6: Only the product of command and vdc_gain matters. Halving both axes and doubling the gain gives the same on-times within ±2 clocks.
- R7: When the line-to-line span vmax − vmin exceeds 1, the largest phase stays on for the whole period and the smallest phase stays off. The middle phase is on for 2·PK·(v − vmin)/span, within ±6 clocks.
- R8: A zero command gives all three phases an on-time of half a period, within ±6 clocks.
- R9: A command change in the middle of a carrier period does not alter that period's on-times. The new on-times take effect in the period that starts at the next period_stb.
- R10: A command of 0.57 of the DC link at 30 degrees stays linear: the shortest phase still has a non-zero on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_alpha | input | W | Alpha-axis voltage command, signed Q1.15 |
| cmd_beta | input | W | Beta-axis voltage command, signed Q1.15 |
| vdc_gain | input | W | Command-to-DC-link scale, unsigned Q2.14 |
| gate_hi | output | 3 | High-side gate per phase (bit 0 = a) |
| gate_lo | output | 3 | Low-side gate per phase, inverse of gate_hi |
| period_stb | output | 1 | High in the carrier valley cycle, once per period |

## Verification
The staging of a new command and the valley load of the active on-times can fall in the same carrier period. The command also keeps being sampled while a period that uses the old one is still running. The bench provokes this by changing the command a few hundred clocks after a strobe and counting that whole period's on-times. Those counts must match the old command, and the counts of the following period must match the new one. Each window also watches the strobe position and the gate complement cycle by cycle, so a load that leaks in early shows up as a wrong count.

// File: rtl/svpwm_mod.sv
module svpwm_mod #(
  parameter int W      = 16,
  parameter int GF     = 14,
  parameter int CLK_HZ = 125_000_000,
  parameter int PWM_HZ = 100_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] cmd_alpha,
  input  logic signed [W-1:0] cmd_beta,
  input  logic        [W-1:0] vdc_gain,
  output logic        [2:0]   gate_hi,
  output logic        [2:0]   gate_lo,
  output logic                period_stb
);
  localparam int PK = CLK_HZ / (2 * PWM_HZ);
  localparam int CW = $clog2(PK + 1);
  localparam int PW = 2 * W + 8;
  localparam int FB = W - 1;
  localparam logic signed [PW-1:0] ZERO = '0;
  localparam logic signed [PW-1:0] KS3  = PW'(28378);
  localparam logic signed [PW-1:0] KS32 = PW'(14189);
  localparam logic signed [PW-1:0] KPK  = PW'(PK);
  localparam logic [CW-1:0] PKC = CW'(PK);

  logic signed [PW-1:0] an, bn, a3, hb, xv, yv, zv, d1r, d2r, c1, c2, sum;
  logic signed [PW-1:0] c1s, c2s, hz, pa, pb, pc;
  logic [2:0] code, sec;
  logic [2:0][CW-1:0] dnew, dsh, dact;
  logic [CW-1:0] cnt;
  logic up;

  assign an = (PW'(cmd_alpha) * PW'($signed({1'b0, vdc_gain}))) >>> GF;
  assign bn = (PW'(cmd_beta)  * PW'($signed({1'b0, vdc_gain}))) >>> GF;
  assign a3 = (an * KS3) >>> 14;
  assign hb = (bn * KS32) >>> 14;
  assign xv = (bn * KS3) >>> 14;
  assign yv = an + (an >>> 1) + hb;
  assign zv = hb - an - (an >>> 1);
  assign code = {(-a3 - bn) > ZERO, (a3 - bn) > ZERO, bn > ZERO};

  always_comb begin
    case (code)
      3'd3:    sec = 3'd0;
      3'd1:    sec = 3'd1;
      3'd5:    sec = 3'd2;
      3'd4:    sec = 3'd3;
      3'd6:    sec = 3'd4;
      3'd2:    sec = 3'd5;
      default: sec = 3'd0;
    endcase
    case (sec)
      3'd0:    begin d1r = -zv; d2r = xv;  end
      3'd1:    begin d1r = yv;  d2r = zv;  end
      3'd2:    begin d1r = xv;  d2r = -yv; end
      3'd3:    begin d1r = zv;  d2r = -xv; end
      3'd4:    begin d1r = -yv; d2r = -zv; end
      default: begin d1r = -xv; d2r = yv;  end
    endcase
    c1  = (d1r < ZERO) ? ZERO : (d1r * KPK) >>> FB;
    c2  = (d2r < ZERO) ? ZERO : (d2r * KPK) >>> FB;
    sum = c1 + c2;
    if (sum > KPK) begin
      c1s = (c1 * KPK) / sum;
      c2s = KPK - c1s;
      hz  = ZERO;
    end else begin
      c1s = c1;
      c2s = c2;
      hz  = (KPK - sum) >>> 1;
    end
    case (sec)
      3'd0:    begin pa = c1s + c2s + hz; pb = c2s + hz;       pc = hz;             end
      3'd1:    begin pa = c1s + hz;       pb = c1s + c2s + hz; pc = hz;             end
      3'd2:    begin pa = hz;             pb = c1s + c2s + hz; pc = c2s + hz;       end
      3'd3:    begin pa = hz;             pb = c1s + hz;       pc = c1s + c2s + hz; end
      3'd4:    begin pa = c2s + hz;       pb = hz;             pc = c1s + c2s + hz; end
      default: begin pa = c1s + c2s + hz; pb = hz;             pc = c1s + hz;       end
    endcase
    dnew[0] = pa[CW-1:0];
    dnew[1] = pb[CW-1:0];
    dnew[2] = pc[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      up   <= 1'b1;
      dsh  <= '0;
      dact <= '0;
    end else begin
      dsh <= dnew;
      if (cnt == '0) dact <= dsh;
      if (up) begin
        cnt <= cnt + 1'b1;
        if (cnt == PKC - 1'b1) up <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) up <= 1'b1;
      end
    end
  end

  assign period_stb = (cnt == '0);

  for (genvar g = 0; g < 3; g++) begin : g_leg
    assign gate_hi[g] = rst_n && (cnt < dact[g]);
    assign gate_lo[g] = ~gate_hi[g];
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= PKC); // R2
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) period_stb |=> !period_stb); // R2
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !period_stb |=> $stable(dact)); // R9
  AST_DUTY_MAX: assert property (@(posedge clk) disable iff (!rst_n) (dact[0] <= PKC) && (dact[1] <= PKC) && (dact[2] <= PKC)); // R4
  AST_CLIP_FULL: assert property (@(posedge clk) disable iff (!rst_n) (sum > KPK) |=> ((dsh[0] == PKC) || (dsh[1] == PKC) || (dsh[2] == PKC))); // R7
  AST_CLIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (sum > KPK) |=> ((dsh[0] == '0) || (dsh[1] == '0) || (dsh[2] == '0))); // R7
endmodule

// File: tb/svpwm_mod_bench.sv
`timescale 1ns/1ps
module svpwm_mod_bench;
  localparam int PK = 625;
  localparam int N  = 2 * PK;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] cmd_alpha = '0;
  logic signed [15:0] cmd_beta = '0;
  logic [15:0] vdc_gain = 16'd16384;
  logic [2:0] gate_hi, gate_lo;
  logic period_stb;
  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  svpwm_mod u_svpwm_mod (.clk(clk), .rst_n(rst_n), .cmd_alpha(cmd_alpha), .cmd_beta(cmd_beta),
    .vdc_gain(vdc_gain), .gate_hi(gate_hi), .gate_lo(gate_lo), .period_stb(period_stb));

  task automatic check_near(input string tag, input int act, input int exp, input int tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int g);
    @(negedge clk);
    cmd_alpha = 16'(a);
    cmd_beta  = 16'(b);
    vdc_gain  = 16'(g);
  endtask

  task automatic expect_on(input int a, input int b, input int g, output int ea, output int eb, output int ec);
    real n, al, be, v[3], mx, mn, span, d;
    int e[3];
    n  = real'(g) / 16384.0;
    al = n * real'(a) / 32768.0;
    be = n * real'(b) / 32768.0;
    v[0] = al;
    v[1] = -al / 2.0 + $sqrt(3.0) / 2.0 * be;
    v[2] = -al / 2.0 - $sqrt(3.0) / 2.0 * be;
    mx = v[0]; mn = v[0];
    for (int i = 1; i < 3; i++) begin
      if (v[i] > mx) mx = v[i];
      if (v[i] < mn) mn = v[i];
    end
    span = mx - mn;
    for (int i = 0; i < 3; i++) begin
      if (span > 1.0) d = (v[i] - mn) / span;
      else d = 0.5 + v[i] - (mx + mn) / 2.0;
      e[i] = $rtoi(real'(N) * d + 0.5);
    end
    ea = e[0]; eb = e[1]; ec = e[2];
  endtask

  task automatic wait_stb();
    do @(negedge clk); while (!period_stb);
  endtask

  // Counts one carrier period starting at a strobe; optionally changes command mid-way.
  task automatic count_window(input int chg_at, input int na, input int nb, output int ha, output int hb, output int hc);
    int mism = 0;
    int stbbad = 0;
    ha = 0; hb = 0; hc = 0;
    for (int k = 1; k <= N; k++) begin
      @(negedge clk);
      if (k == chg_at) begin
        cmd_alpha = 16'(na);
        cmd_beta  = 16'(nb);
      end
      ha += int'(gate_hi[0]);
      hb += int'(gate_hi[1]);
      hc += int'(gate_hi[2]);
      if (gate_lo !== ~gate_hi) mism++;
      if (period_stb && k != N) stbbad++;
      if (!period_stb && k == N) stbbad++;
    end
    check_near("R3 complement mismatches", mism, 0, 0);
    check_near("R2 strobe position errors", stbbad, 0, 0);
  endtask

  task automatic run_case(input string tag, input int a, input int b, input int g, output int ha, output int hb, output int hc);
    int ea, eb, ec;
    apply(a, b, g);
    repeat (3) @(negedge clk);
    wait_stb();
    count_window(0, 0, 0, ha, hb, hc);
    expect_on(a, b, g, ea, eb, ec);
    check_near({tag, " phase a"}, ha, ea, 6);
    check_near({tag, " phase b"}, hb, eb, 6);
    check_near({tag, " phase c"}, hc, ec, 6);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check_near("R1 gate_hi in reset", int'(gate_hi), 0, 0);
    check_near("R1 gate_lo in reset", int'(gate_lo), 7, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_period();
    int gap = 0;
    wait_stb();
    do begin @(negedge clk); gap++; end while (!period_stb);
    check_near("R2 strobe spacing", gap, N, 0);
  endtask

  task automatic t_zero();
    int ha, hb, hc;
    run_case("R8 zero command", 0, 0, 16384, ha, hb, hc);
  endtask

  task automatic t_sectors();
    int ha, hb, hc, mx, mn;
    for (int s = 0; s < 6; s++) begin
      real ang = (20.0 + 60.0 * s) * PI / 180.0;
      int a = $rtoi(0.4 * 32768.0 * $cos(ang));
      int b = $rtoi(0.4 * 32768.0 * $sin(ang));
      run_case($sformatf("R4 sector %0d", s), a, b, 16384, ha, hb, hc);
      mx = ha; mn = ha;
      if (hb > mx) mx = hb;
      if (hc > mx) mx = hc;
      if (hb < mn) mn = hb;
      if (hc < mn) mn = hc;
      check_near($sformatf("R5 zero split sector %0d", s), mx + mn, N, 6);
    end
  endtask

  task automatic t_edge30();
    int ha, hb, hc, a, b;
    a = $rtoi(0.57 * 32768.0 * $cos(PI / 6.0));
    b = $rtoi(0.57 * 32768.0 * $sin(PI / 6.0));
    run_case("R4 edge 30deg", a, b, 16384, ha, hb, hc);
    checks++;
    if (hc < 1) begin
      fails++;
      $display("FAIL R10 shortest on-time actual=%0d expected=>0", hc);
    end
  endtask

  task automatic t_overmod();
    int ha, hb, hc;
    run_case("R7 clip 10deg", $rtoi(0.8 * 32768.0 * $cos(PI / 18.0)), $rtoi(0.8 * 32768.0 * $sin(PI / 18.0)), 16384, ha, hb, hc);
    check_near("R7 full phase a", ha, N - 1, 1);
    check_near("R7 off phase c", hc, 0, 0);
    run_case("R7 clip 200deg", $rtoi(0.8 * 32768.0 * $cos(PI * 200.0 / 180.0)), $rtoi(0.8 * 32768.0 * $sin(PI * 200.0 / 180.0)), 16384, ha, hb, hc);
  endtask

  task automatic t_gain();
    int a1, b1, c1, a2, b2, c2;
    run_case("R6 gain 1.0", 12000, 6000, 16384, a1, b1, c1);
    run_case("R6 gain 2.0", 6000, 3000, 32768, a2, b2, c2);
    check_near("R6 same on-time a", a2, a1, 2);
    check_near("R6 same on-time b", b2, b1, 2);
    check_near("R6 same on-time c", c2, c1, 2);
  endtask

  task automatic t_update();
    int ha, hb, hc, ea, eb, ec, fa, fb, fc, a0, b0, a1, b1;
    a0 = $rtoi(0.3 * 32768.0 * $cos(PI / 18.0));
    b0 = $rtoi(0.3 * 32768.0 * $sin(PI / 18.0));
    a1 = -a0; b1 = -b0;
    run_case("R9 settle", a0, b0, 16384, ha, hb, hc);
    expect_on(a0, b0, 16384, ea, eb, ec);
    expect_on(a1, b1, 16384, fa, fb, fc);
    wait_stb();
    count_window(400, a1, b1, ha, hb, hc);
    check_near("R9 mid-period keeps old a", ha, ea, 6);
    check_near("R9 mid-period keeps old c", hc, ec, 6);
    count_window(0, 0, 0, ha, hb, hc);
    check_near("R9 next period new a", ha, fa, 6);
    check_near("R9 next period new c", hc, fc, 6);
  endtask

  initial begin
    t_reset();
    t_period();
    t_zero();
    t_sectors();
    t_edge30();
    t_overmod();
    t_gain();
    t_update();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule